// File: doc/BRIEF.md
# Wide-Result Arithmetic Logic Unit

This block is the arithmetic-logic unit of a 16-bit register-transfer datapath that has a 32-bit extension. It has three operand inputs: the primary buffer operand, the high buffer operand and the operand currently on the shared bus. It has two result registers: the primary result and the high result. A function-select code chooses the operation. Both result registers capture on a single load strobe. Single-width operations (add, subtract, and, or, not, and add-immediate with a 5-bit or 8-bit sign-extended constant) write only the primary result.

Multiply forms an unsigned 16x16 product and splits it across the two result registers. Divide treats the two buffer operands as one 32-bit unsigned dividend, with the high buffer operand forming the upper half. It divides by the bus operand and returns the quotient and the remainder in the same step. Two sticky-per-load flags report a zero divisor and a quotient that does not fit in 16 bits. The bus steps that later move the two results to their destination registers happen outside this block.

Top module: `wide_alsu`

## Requirements
- R1: After a clock edge with `rst_n` low, `c_out`, `ch_out`, `div_err` and `div_ovf` are all zero.
- R2: With `load` high, code 0 writes `a_in + bus_in` and code 1 writes `a_in - bus_in`, both modulo 2^16, into `c_out` on the next edge.
- R3: With `load` high, code 2 writes the bitwise AND and code 3 writes the bitwise OR of `a_in` and `bus_in` into `c_out`.
- R4: With `load` high, code 4 writes the one's complement of `bus_in` into `c_out`, and `a_in` has no effect on the result.
- R5: With `load` high, code 5 writes `a_in` plus `imm_in[4:0]` into `c_out`, after the constant is widened by copying its bit 4 into bits 15..5. `imm_in[7:5]` has no effect.
- R6: With `load` high, code 6 writes `a_in` plus `imm_in[7:0]` into `c_out`, after the constant is widened by copying its bit 7 into bits 15..8.
- R7: With `load` high, code 7 writes the unsigned product `a_in * bus_in`, with bits 31..16 into `ch_out` and bits 15..0 into `c_out`.
- R8: With `load` high and a nonzero `bus_in`, code 8 divides the unsigned dividend `{ah_in, a_in}` by `bus_in`. The low 16 bits of the quotient go to `c_out` and the remainder goes to `ch_out` on the same edge.
- R9: On code 8 with `bus_in` equal to zero, `div_err` is set to 1, `c_out` becomes 16'hFFFF and `ch_out` becomes `a_in`.
- R10: On code 8 with a nonzero divisor, `div_ovf` is set to 1 exactly when the quotient is 2^16 or larger, and `c_out` then holds the truncated low 16 bits. `div_ovf` and `div_err` are never both 1.
- R11: Codes 0 to 7 clear both flags. Codes 0 to 6 leave `ch_out` unchanged.
- R12: While `load` is low, or when `load` is high with a code from 9 to 15, all four outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Function-select code (0..8 used, 9..15 reserved) |
| load | input | 1 | Capture strobe for the result registers and flags |
| a_in | input | 16 | Primary buffer operand (low half of the dividend) |
| ah_in | input | 16 | High buffer operand (high half of the dividend) |
| bus_in | input | 16 | Bus operand, divisor and multiplier |
| imm_in | input | 8 | Immediate constant field |
| c_out | output | 16 | Primary result register |
| ch_out | output | 16 | High result register |
| div_err | output | 1 | Zero-divisor flag from the last divide |
| div_ovf | output | 1 | Quotient-overflow flag from the last divide |

## Verification
Multiply is tried with random operands and with all-ones operands. All-ones operands are the only way to exercise the top carries of the partial-product array and a high half near 16'hFFFE. Divide is tried in four ways:
- With the high buffer operand reduced below the divisor, so every quotient fits and the quotient/remainder split is checked.
- With an unrestricted high half, which separates correct overflow flagging and truncation from a wrong quotient.
- With a zero divisor.
- With divisor one and a dividend of 2^16, which shows whether the bit ordering of the quotient stages is wrong.

Immediate adds use constants with the sign bit set and with stray high bits, which distinguishes sign extension from zero extension and from use of the wrong field width.

// File: rtl/wide_alsu_pkg.sv
// Package: shared function codes for the wide-result ALU.
// Assumes op codes are 4 bits wide; codes above OP_DIV are reserved.
package wide_alsu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_NOT   = 4'd4,
        OP_ADDS  = 4'd5,
        OP_ADDL  = 4'd6,
        OP_MUL   = 4'd7,
        OP_DIV   = 4'd8
    } alsu_op_e;

    // Codes whose result fits in the primary register only.
    function automatic logic is_narrow(input logic [3:0] code);
        return code <= 4'd6;
    endfunction

endpackage

// File: rtl/wide_alsu_logic.sv
// Single-width arithmetic and logic section.
// Computes add, subtract, and, or, not and the two immediate adds.
// Assumes the short and long immediates sit right-aligned in imm.
// The result is combinational and is meaningful only for the narrow codes.
module wide_alsu_logic
    import wide_alsu_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_S = 5,
    parameter int IMM_L = 8
) (
    input  logic [3:0]       op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [IMM_L-1:0] imm,
    output logic [W-1:0]     res
);
    localparam int PAD_S = W - IMM_S;
    localparam int PAD_L = W - IMM_L;

    logic [W-1:0] imm_short_x;
    logic [W-1:0] imm_long_x;

    // Widen both constants by replicating their top bit.
    always_comb begin
        imm_short_x = {{PAD_S{imm[IMM_S-1]}}, imm[IMM_S-1:0]};
        imm_long_x  = {{PAD_L{imm[IMM_L-1]}}, imm};
    end

    // Pick the single-width result for the selected code.
    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_NOT:  res = ~b;
            OP_ADDS: res = a + imm_short_x;
            OP_ADDL: res = a + imm_long_x;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/wide_alsu_mul.sv
// Unsigned W x W multiplier built as an unrolled shift-add chain.
// Each stage conditionally adds the shifted multiplicand.
// Assumes unsigned operands. The product is combinational and 2W bits wide.
module wide_alsu_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int W2 = 2 * W;

    logic [W:0][W2-1:0] acc;
    logic [W2-1:0]      a_wide;

    // Zero-extend the multiplicand to the product width.
    always_comb a_wide = {{W{1'b0}}, a};

    assign acc[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        // Add the multiplicand shifted by i when bit i of the multiplier is set.
        assign acc[i+1] = acc[i] + (b[i] ? (a_wide << i) : '0);
    end

    assign prod = acc[W];
endmodule

// File: rtl/wide_alsu_div.sv
// Unsigned 2W-by-W divider built as an unrolled restoring chain.
// One stage per dividend bit, starting with the most significant bit.
// Assumes a nonzero divisor for meaningful output. The caller handles a zero
// divisor. The full 2W-bit quotient is returned so that overflow can be seen.
module wide_alsu_div #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] dvd,
    input  logic [W-1:0]   dvs,
    output logic [2*W-1:0] quo,
    output logic [W-1:0]   rem
);
    localparam int W2 = 2 * W;

    logic [W2:0][W-1:0] part;
    logic [W:0]         dvs_x;

    // Widen the divisor by one bit to compare against the shifted remainder.
    always_comb dvs_x = {1'b0, dvs};

    assign part[0] = '0;

    for (genvar i = 0; i < W2; i++) begin : g_step
        logic [W:0] trial;
        logic [W:0] diff;
        logic       fits;
        // Shift in the next dividend bit and subtract the divisor when it fits.
        assign trial = {part[i], dvd[W2-1-i]};
        assign fits  = (trial >= dvs_x);
        assign diff  = trial - dvs_x;
        assign quo[W2-1-i] = fits;
        assign part[i+1]   = fits ? diff[W-1:0] : trial[W-1:0];
    end

    assign rem = part[W2];
endmodule

// File: rtl/wide_alsu.sv
// Wide-result ALU top.
// Selects among single-width, multiply and divide results and registers them
// into the primary and high result registers on a load strobe.
// Assumes inputs are stable in the load cycle. All results appear one edge later.
// Reset is synchronous and active low.
module wide_alsu
    import wide_alsu_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_S = 5,
    parameter int IMM_L = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_sel,
    input  logic             load,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     ah_in,
    input  logic [W-1:0]     bus_in,
    input  logic [IMM_L-1:0] imm_in,
    output logic [W-1:0]     c_out,
    output logic [W-1:0]     ch_out,
    output logic             div_err,
    output logic             div_ovf
);
    localparam int W2 = 2 * W;

    logic [W-1:0]  narrow_res;
    logic [W2-1:0] product;
    logic [W2-1:0] quotient;
    logic [W-1:0]  remainder;
    logic          dvs_zero;
    logic          quo_wide;

    wide_alsu_logic #(.W(W), .IMM_S(IMM_S), .IMM_L(IMM_L)) u_logic (
        .op  (op_sel),
        .a   (a_in),
        .b   (bus_in),
        .imm (imm_in),
        .res (narrow_res)
    );

    wide_alsu_mul #(.W(W)) u_mul (
        .a    (a_in),
        .b    (bus_in),
        .prod (product)
    );

    wide_alsu_div #(.W(W)) u_div (
        .dvd ({ah_in, a_in}),
        .dvs (bus_in),
        .quo (quotient),
        .rem (remainder)
    );

    // Classify the divide outcome.
    always_comb begin
        dvs_zero = (bus_in == '0);
        quo_wide = !dvs_zero && (quotient[W2-1:W] != '0);
    end

    // Result and flag registers: capture on load for the valid codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_out   <= '0;
            ch_out  <= '0;
            div_err <= 1'b0;
            div_ovf <= 1'b0;
        end else if (load) begin
            if (is_narrow(op_sel)) begin
                c_out   <= narrow_res;
                div_err <= 1'b0;
                div_ovf <= 1'b0;
            end else if (op_sel == OP_MUL) begin
                c_out   <= product[W-1:0];
                ch_out  <= product[W2-1:W];
                div_err <= 1'b0;
                div_ovf <= 1'b0;
            end else if (op_sel == OP_DIV) begin
                div_err <= dvs_zero;
                div_ovf <= quo_wide;
                if (dvs_zero) begin
                    c_out  <= '1;
                    ch_out <= a_in;
                end else begin
                    c_out  <= quotient[W-1:0];
                    ch_out <= remainder;
                end
            end
        end
    end
endmodule

// File: rtl/wide_alsu_chk.sv
// Checker for the wide-result ALU.
// Relates the strobe, codes and operands to the registered outputs one edge later.
module wide_alsu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_sel,
    input logic         load,
    input logic [W-1:0] a_in,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] c_out,
    input logic [W-1:0] ch_out,
    input logic         div_err,
    input logic         div_ovf
);
    localparam int W2 = 2 * W;

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load || op_sel > 4'd8) |=> ($stable(c_out) && $stable(ch_out)
                                      && $stable(div_err) && $stable(div_ovf)));

    p_ch_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_sel <= 4'd6) |=> ($stable(ch_out) && !div_err && !div_ovf));

    p_not_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_sel == 4'd4) |=> (c_out == ~$past(bus_in)));

    p_mul_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_sel == 4'd7) |=>
        ({ch_out, c_out} == (W2'($past(a_in)) * W2'($past(bus_in)))));

    p_div_rem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_sel == 4'd8 && bus_in != '0) |=> (ch_out < $past(bus_in)));

    p_div_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_sel == 4'd8 && bus_in == '0) |=>
        (div_err && c_out == '1 && ch_out == $past(a_in)));

    p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        div_ovf |-> !div_err);
endmodule

bind wide_alsu wide_alsu_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .load    (load),
    .a_in    (a_in),
    .bus_in  (bus_in),
    .c_out   (c_out),
    .ch_out  (ch_out),
    .div_err (div_err),
    .div_ovf (div_ovf)
);

// File: tb/wide_alsu_bench.sv
`timescale 1ns/1ps
module wide_alsu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        load = 1'b0;
    logic [15:0] a_in = '0, ah_in = '0, bus_in = '0;
    logic [7:0]  imm_in = '0;
    logic [15:0] c_out, ch_out;
    logic        div_err, div_ovf;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state, kept from the requirements.
    logic [15:0] m_c = '0, m_ch = '0;
    logic        m_err = 1'b0, m_ovf = 1'b0;

    wide_alsu u_wide_alsu (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .load(load),
        .a_in(a_in), .ah_in(ah_in), .bus_in(bus_in), .imm_in(imm_in),
        .c_out(c_out), .ch_out(ch_out), .div_err(div_err), .div_ovf(div_ovf)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2 R11";
            4'd2, 4'd3: return "R3 R11";
            4'd4:       return "R4 R11";
            4'd5:       return "R5 R11";
            4'd6:       return "R6 R11";
            4'd7:       return "R7 R11";
            4'd8:       return "R8 R9 R10";
            default:    return "R12";
        endcase
    endfunction

    // Update the reference state for one strobed operation.
    task automatic model(input logic [3:0] op, input logic [15:0] a,
                         input logic [15:0] ah, input logic [15:0] b,
                         input logic [7:0] imm);
        logic [31:0] dvd, q, p;
        dvd = {ah, a};
        if (op <= 4'd7) begin m_err = 1'b0; m_ovf = 1'b0; end
        case (op)
            4'd0: m_c = a + b;
            4'd1: m_c = a - b;
            4'd2: m_c = a & b;
            4'd3: m_c = a | b;
            4'd4: m_c = ~b;
            4'd5: m_c = a + {{11{imm[4]}}, imm[4:0]};
            4'd6: m_c = a + {{8{imm[7]}}, imm};
            4'd7: begin
                p = {16'd0, a} * {16'd0, b};
                m_c = p[15:0];
                m_ch = p[31:16];
            end
            4'd8: begin
                if (b == 16'd0) begin
                    m_err = 1'b1; m_ovf = 1'b0; m_c = 16'hFFFF; m_ch = a;
                end else begin
                    q = dvd / {16'd0, b};
                    m_err = 1'b0;
                    m_ovf = (q[31:16] != 16'd0);
                    m_c = q[15:0];
                    m_ch = 16'(dvd % {16'd0, b});
                end
            end
            default: ;
        endcase
    endtask

    task automatic check(input string tag);
        n_chk++;
        if ({c_out, ch_out, div_err, div_ovf} !== {m_c, m_ch, m_err, m_ovf}) begin
            n_bad++;
            $display("FAIL %s: actual c=%h ch=%h err=%b ovf=%b expected c=%h ch=%h err=%b ovf=%b",
                     tag, c_out, ch_out, div_err, div_ovf, m_c, m_ch, m_err, m_ovf);
        end
    endtask

    // Apply one operation with a one-cycle strobe and check after the edge.
    task automatic run_op(input logic [3:0] op, input logic [15:0] a,
                          input logic [15:0] ah, input logic [15:0] b,
                          input logic [7:0] imm);
        op_sel = op; a_in = a; ah_in = ah; bus_in = b; imm_in = imm; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        model(op, a, ah, b, imm);
        check(tag_of(op));
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // Directed cases.
        run_op(4'd7, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0);   // R7 all-ones product
        run_op(4'd0, 16'hFFFF, 16'h0, 16'h0002, 8'h0);   // R2 wrap, R11 keeps ch
        run_op(4'd1, 16'h0001, 16'h0, 16'h0003, 8'h0);   // R2 borrow
        run_op(4'd4, 16'h1234, 16'h0, 16'h00F0, 8'h0);   // R4 a ignored
        run_op(4'd5, 16'h0100, 16'h0, 16'h0, 8'hF0);     // R5 -16, high bits ignored
        run_op(4'd5, 16'h0100, 16'h0, 16'h0, 8'h0F);     // R5 +15
        run_op(4'd6, 16'h0100, 16'h0, 16'h0, 8'h80);     // R6 -128
        run_op(4'd8, 16'h0000, 16'h0001, 16'h0001, 8'h0); // R10 quotient 2^16
        run_op(4'd8, 16'hABCD, 16'h0007, 16'h0000, 8'h0); // R9 zero divisor
        run_op(4'd2, 16'hF0F0, 16'h0, 16'h3C3C, 8'h0);   // R11 flags cleared
        run_op(4'd8, 16'h1234, 16'h0002, 16'h0010, 8'h0); // R8 fits
        run_op(4'd8, 16'hFFFF, 16'hFFFE, 16'hFFFF, 8'h0); // R8 max fitting

        // R12: inputs move with no strobe, then reserved codes with a strobe.
        op_sel = 4'd0; a_in = 16'h7777; bus_in = 16'h1111; load = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 no load");
        run_op(4'd9, 16'h5555, 16'h1, 16'h2222, 8'h11);
        run_op(4'd15, 16'h5555, 16'h1, 16'h0000, 8'h11);

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  op;
            logic [15:0] a, ah, b;
            logic [7:0]  imm;
            op  = 4'($urandom_range(0, 9));
            a   = 16'($urandom);
            b   = 16'($urandom);
            ah  = 16'($urandom);
            imm = 8'($urandom);
            if (op == 4'd8) begin
                case ($urandom_range(0, 3))
                    0: b = 16'd0;
                    1: ah = 16'd0;
                    2: ;
                    default: if (b != 16'd0) ah = ah % b;
                endcase
            end
            run_op(op, a, ah, b, imm);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule